// File: doc/BRIEF.md
# DMA Channel Condition Flags and Interrupt Gate

This block keeps the condition state of a single DMA channel. The transfer engine reports six kinds of event as one-cycle set pulses: block done, frame done, last frame, sync miss, write drop and read drop. Each pulse sets a sticky flag. Each flag has its own enable bit. Software reads and writes both the flags and the enables through a small byte-wide register port. Software can clear a flag but can never set one. A per-condition strobe from the transfer engine also clears a flag, but only while that flag's enable bit is off.

The channel interrupt line is high when a channel-level transfer-complete enable input is high and at least one flag is set together with its enable bit. Three of the conditions are warnings: sync miss, write drop and read drop. When any warning is set and enabled, the block raises a pause request for the channel sequencer, whatever the state of the transfer-complete enable. A CPU-side edge detector turns each low-to-high change of the interrupt line into a single-cycle pulse.

Top module: `dma_cond_irq`

## Requirements
- R1: After reset all six flags read 0, the enable byte reads 0x01 (only block done enabled), and `chan_irq`, `pause_req` and `cpu_irq_pulse` are all 0.
- R2: A high `cond_set` bit sets the matching flag at the next clock edge. Flag bit positions are 0 block done, 1 frame done, 2 last frame, 3 sync miss, 4 write drop and 5 read drop. Writing 1 to a flag bit at register address 0 leaves that flag unchanged.
- R3: `chan_irq` is 1 exactly when `tc_int_en` is 1 and some flag is set together with its enable bit. While `tc_int_en` is 0, `chan_irq` stays 0.
- R4: `pause_req` is 1 exactly when flag 3, 4 or 5 is set with its enable bit, independent of `tc_int_en`. A warning flag that is set but not enabled does not raise it.
- R5: A flag whose enable bit is 1 ignores its `cond_hw_clr` strobe. It is cleared by a write of 0 to its bit at address 0.
- R6: A flag whose enable bit is 0 is cleared by its `cond_hw_clr` strobe at the next edge.
- R7: When a set pulse and a clear strobe reach the same flag in the same cycle, the flag ends up set.
- R8: When a set pulse and a software write of 0 reach the same flag in the same cycle, the flag ends up set.
- R9: A write to address 1 loads the enable bits from data bits 5:0. Reads are combinational: address 0 returns the flags and address 1 returns the enables, both in bits 5:0, and bits 7:6 always read 0.
- R10: `cpu_irq_pulse` is high for exactly one cycle each time `chan_irq` goes from 0 to 1, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_int_en | input | 1 | Transfer-complete interrupt enable from the primary control |
| cond_set | input | 6 | Per-condition set pulses from the transfer engine |
| cond_hw_clr | input | 6 | Per-condition hardware clear strobes |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 1 | Register select: 0 flags, 1 enables |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Combinational read data for `reg_addr` |
| chan_irq | output | 1 | Channel interrupt line |
| pause_req | output | 1 | Pause request for enabled warnings |
| cpu_irq_pulse | output | 1 | One-cycle pulse on each rising edge of `chan_irq` |

## Verification
A flag can receive a hardware set in the same cycle as a clear, and the clear can come from either side: the engine's strobe or a software write of 0. The bench provokes both collisions. In one cycle it pulses frame done and its clear strobe together while that flag is not enabled. In another it raises read drop in the cycle that writes zero to the whole flag byte. In both cases the colliding flag must read as set afterwards, and the other flags must follow their own clear rule.

// File: rtl/dma_cond_pkg.sv
package dma_cond_pkg;
   localparam int unsigned COND_N = 6;
   localparam int unsigned REG_W  = 8;

   typedef enum int unsigned {
      C_BLK  = 0,
      C_FRM  = 1,
      C_LST  = 2,
      C_SYNC = 3,
      C_WDRP = 4,
      C_RDRP = 5
   } cond_idx_e;

   // warning conditions: sync miss, write drop, read drop
   localparam logic [COND_N-1:0] WARN_MASK_DEF = 6'b111000;
   // only block done may interrupt out of reset
   localparam logic [COND_N-1:0] IE_RST_DEF    = 6'b000001;
endpackage

// File: rtl/cond_flag_bank.sv
module cond_flag_bank #(
   parameter int unsigned N = 6,
   parameter logic [N-1:0] IE_RESET = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] hwclr_i,
   input  logic         wr_en,
   input  logic         wr_addr,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] flags_o,
   output logic [N-1:0] ie_o
);
   logic [N-1:0] flag_q;
   logic [N-1:0] flag_d;
   logic [N-1:0] ie_q;
   logic         wr_flag;
   logic         wr_ie;

   assign wr_flag = wr_en & ~wr_addr;
   assign wr_ie   = wr_en &  wr_addr;

   for (genvar gi = 0; gi < N; gi++) begin : g_cell
      logic sw_clr;
      logic hw_clr;
      assign sw_clr = wr_flag & ~wdata[gi];
      assign hw_clr = hwclr_i[gi] & ~ie_q[gi];
      // a set pulse beats both clear sources
      assign flag_d[gi] = set_i[gi] | (flag_q[gi] & ~sw_clr & ~hw_clr);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
         ie_q   <= IE_RESET;
      end else begin
         flag_q <= flag_d;
         if (wr_ie) ie_q <= wdata;
      end
   end

   assign flags_o = flag_q;
   assign ie_o    = ie_q;
endmodule

// File: rtl/cond_irq_combine.sv
module cond_irq_combine #(
   parameter int unsigned N = 6,
   parameter logic [N-1:0] WARN_MASK = '0
) (
   input  logic [N-1:0] flags,
   input  logic [N-1:0] ie,
   input  logic         tc_en,
   output logic         irq,
   output logic         pause
);
   logic [N-1:0] live;
   assign live  = flags & ie;
   assign irq   = tc_en & (|live);
   assign pause = |(live & WARN_MASK);
endmodule

// File: rtl/irq_edge_pulse.sv
module irq_edge_pulse #(
   parameter bit REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic pulse
);
   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   if (REGISTERED) begin : g_reg
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= level & ~level_q;
      end
      assign pulse = pulse_q;
   end else begin : g_comb
      assign pulse = level & ~level_q;
   end
endmodule

// File: rtl/dma_cond_irq.sv
module dma_cond_irq
   import dma_cond_pkg::*;
#(
   parameter int unsigned NUM_COND = COND_N,
   parameter int unsigned DATA_W   = REG_W,
   parameter logic [NUM_COND-1:0] WARN_MASK = WARN_MASK_DEF,
   parameter logic [NUM_COND-1:0] IE_RESET  = IE_RST_DEF,
   parameter bit PULSE_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tc_int_en,
   input  logic [NUM_COND-1:0] cond_set,
   input  logic [NUM_COND-1:0] cond_hw_clr,
   input  logic                reg_wr_en,
   input  logic                reg_addr,
   input  logic [DATA_W-1:0]   reg_wr_data,
   output logic [DATA_W-1:0]   reg_rd_data,
   output logic                chan_irq,
   output logic                pause_req,
   output logic                cpu_irq_pulse
);
   localparam int unsigned PAD_W = DATA_W - NUM_COND;

   if (NUM_COND == 0 || NUM_COND >= DATA_W) begin : g_bad_width
      $error("dma_cond_irq: NUM_COND must be nonzero and below DATA_W");
   end

   logic [NUM_COND-1:0] flag_q;
   logic [NUM_COND-1:0] ie_q;

   cond_flag_bank #(.N(NUM_COND), .IE_RESET(IE_RESET)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (cond_set),
      .hwclr_i (cond_hw_clr),
      .wr_en   (reg_wr_en),
      .wr_addr (reg_addr),
      .wdata   (reg_wr_data[NUM_COND-1:0]),
      .flags_o (flag_q),
      .ie_o    (ie_q)
   );

   cond_irq_combine #(.N(NUM_COND), .WARN_MASK(WARN_MASK)) u_comb (
      .flags (flag_q),
      .ie    (ie_q),
      .tc_en (tc_int_en),
      .irq   (chan_irq),
      .pause (pause_req)
   );

   irq_edge_pulse #(.REGISTERED(PULSE_REG)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (chan_irq),
      .pulse (cpu_irq_pulse)
   );

   logic spare_unused;
   assign spare_unused = ^reg_wr_data[DATA_W-1:NUM_COND];

   assign reg_rd_data = {{PAD_W{1'b0}}, (reg_addr ? ie_q : flag_q)};
endmodule

// File: rtl/dma_cond_irq_chk.sv
module dma_cond_irq_chk #(
   parameter int unsigned N = 6,
   parameter logic [N-1:0] WARN_MASK = '0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tc_int_en,
   input logic [N-1:0] cond_set,
   input logic         reg_wr_en,
   input logic         reg_addr,
   input logic [N-1:0] flags,
   input logic [N-1:0] ie,
   input logic         chan_irq,
   input logic         pause_req,
   input logic         cpu_irq_pulse
);
   p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|cond_set) |=> ((flags & $past(cond_set)) == $past(cond_set)));

   p_no_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & ~$past(flags) & ~$past(cond_set)) == '0));

   p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tc_int_en |-> !chan_irq);

   p_pause_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pause_req |-> ((flags & ie & WARN_MASK) != '0));

   p_enabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && !reg_addr) |=> ((~flags & $past(flags & ie)) == '0));

   p_pulse_on_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_pulse |-> chan_irq);

   p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_pulse |=> !cpu_irq_pulse);
endmodule

bind dma_cond_irq dma_cond_irq_chk #(.N(NUM_COND), .WARN_MASK(WARN_MASK)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tc_int_en     (tc_int_en),
   .cond_set      (cond_set),
   .reg_wr_en     (reg_wr_en),
   .reg_addr      (reg_addr),
   .flags         (flag_q),
   .ie            (ie_q),
   .chan_irq      (chan_irq),
   .pause_req     (pause_req),
   .cpu_irq_pulse (cpu_irq_pulse)
);

// File: tb/dma_cond_irq_bench.sv
module dma_cond_irq_bench;
   localparam int CLK_P = 10;
   localparam int NV = 13;
   // {tc, set[5:0], hwclr[5:0], wr, addr, wdata[7:0], exp_flags[5:0], exp_irq, exp_pause}
   localparam logic [30:0] VEC [NV] = '{
      {1'b1, 6'b000001, 6'b000000, 1'b0, 1'b0, 8'h00, 6'b000001, 1'b1, 1'b0}, // R2 R3
      {1'b0, 6'b000000, 6'b000000, 1'b0, 1'b0, 8'h00, 6'b000001, 1'b0, 1'b0}, // R3 gate
      {1'b1, 6'b000000, 6'b000001, 1'b0, 1'b0, 8'h00, 6'b000001, 1'b1, 1'b0}, // R5 strobe ignored
      {1'b1, 6'b000000, 6'b000000, 1'b1, 1'b0, 8'h00, 6'b000000, 1'b0, 1'b0}, // R5 sw clear
      {1'b1, 6'b001000, 6'b000000, 1'b0, 1'b0, 8'h00, 6'b001000, 1'b0, 1'b0}, // R4 not enabled
      {1'b1, 6'b000000, 6'b001000, 1'b0, 1'b0, 8'h00, 6'b000000, 1'b0, 1'b0}, // R6
      {1'b1, 6'b000000, 6'b000000, 1'b1, 1'b1, 8'h38, 6'b000000, 1'b0, 1'b0}, // R9 enables
      {1'b0, 6'b010000, 6'b000000, 1'b0, 1'b0, 8'h00, 6'b010000, 1'b0, 1'b1}, // R4 tc low
      {1'b1, 6'b000000, 6'b000000, 1'b0, 1'b0, 8'h00, 6'b010000, 1'b1, 1'b1}, // R3 R4
      {1'b1, 6'b000010, 6'b000010, 1'b0, 1'b0, 8'h00, 6'b010010, 1'b1, 1'b1}, // R7
      {1'b1, 6'b000000, 6'b000000, 1'b1, 1'b0, 8'h3F, 6'b010010, 1'b1, 1'b1}, // R2 write ones
      {1'b1, 6'b100000, 6'b000000, 1'b1, 1'b0, 8'h00, 6'b100000, 1'b1, 1'b1}, // R8
      {1'b1, 6'b000000, 6'b000000, 1'b1, 1'b0, 8'h00, 6'b000000, 1'b0, 1'b0}  // R5 R6
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tc_int_en = 1'b0;
   logic [5:0] cond_set = '0;
   logic [5:0] cond_hw_clr = '0;
   logic       reg_wr_en = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wr_data = '0;
   logic [7:0] reg_rd_data;
   logic       chan_irq;
   logic       pause_req;
   logic       cpu_irq_pulse;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dma_cond_irq u_dma_cond_irq (
      .clk(clk), .rst_n(rst_n), .tc_int_en(tc_int_en), .cond_set(cond_set),
      .cond_hw_clr(cond_hw_clr), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .chan_irq(chan_irq),
      .pause_req(pause_req), .cpu_irq_pulse(cpu_irq_pulse)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      reg_addr = a;
      #1 v = reg_rd_data;
   endtask

   initial begin
      #(CLK_P*200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(1'b0, v); chk("R1 flags", v, 8'h00);
      rd(1'b1, v); chk("R1 enables", v, 8'h01);
      chk("R1 outputs", {5'b0, chan_irq, pause_req, cpu_irq_pulse}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         tc_int_en   = VEC[i][30];
         cond_set    = VEC[i][29:24];
         cond_hw_clr = VEC[i][23:18];
         reg_wr_en   = VEC[i][17];
         reg_addr    = VEC[i][16];
         reg_wr_data = VEC[i][15:8];
         @(posedge clk);
         @(negedge clk);
         cond_set = '0; cond_hw_clr = '0; reg_wr_en = 1'b0;
         rd(1'b0, v);
         chk($sformatf("R2-row%0d flags", i), v, {2'b0, VEC[i][7:2]});
         chk($sformatf("R3 row%0d irq", i), {7'b0, chan_irq}, {7'b0, VEC[i][1]});
         chk($sformatf("R4 row%0d pause", i), {7'b0, pause_req}, {7'b0, VEC[i][0]});
      end

      // R9 enable write and read-back with upper bits masked
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = 1'b1; reg_wr_data = 8'hFF;
      @(posedge clk); @(negedge clk);
      reg_wr_en = 1'b0;
      rd(1'b1, v); chk("R9 enables", v, 8'h3F);
      rd(1'b0, v); chk("R9 flags upper", v, 8'h00);

      // R10 pulse on rising edge from an event
      tc_int_en = 1'b1; cond_set = 6'b000100;
      @(posedge clk); @(negedge clk);
      cond_set = '0;
      chk("R10 pulse high", {7'b0, cpu_irq_pulse}, 8'h01);
      @(negedge clk);
      chk("R10 pulse one cycle", {7'b0, cpu_irq_pulse}, 8'h00);
      chk("R3 irq held", {7'b0, chan_irq}, 8'h01);
      // R10 rising edge again via the gate
      tc_int_en = 1'b0;
      @(negedge clk);
      chk("R10 no pulse on fall", {7'b0, cpu_irq_pulse}, 8'h00);
      tc_int_en = 1'b1;
      #1 chk("R10 pulse on regate", {7'b0, cpu_irq_pulse}, 8'h01);
      @(negedge clk);
      chk("R10 pulse drops", {7'b0, cpu_irq_pulse}, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule